// File: doc/BRIEF.md
# Majority-Vote Combined Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Three untagged tables of 2-bit saturating counters are read in parallel for every fetch address. The bimodal table is indexed by the branch address. The gshare table is indexed by that address XORed with the global history. The third table is indexed by the global history alone. The prediction is the 2-of-3 majority of the three counters' upper bits.

Lookup is combinational from the current state. Along with the prediction, it returns a snapshot holding the three indices it used and the history value. The fetch side keeps that snapshot with the branch. When the branch resolves, possibly many cycles later, the update port receives the snapshot, the actual outcome and a mispredict flag.

The update trains all three counters at the saved indices, so later history movement cannot misdirect it. It then advances the global history. On a mispredict the history is first rebuilt from the snapshot. No tags are kept, so branches that share low address bits share counters.

Top module: `tri_vote_bpred`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and the history is zero. Every lookup therefore predicts not-taken and reports a history field of 0.
- R2: The bimodal index is lookup_pc_i[IDX_W+1:2] and appears in snap_o[IDX_W-1:0].
- R3: The gshare index is the bimodal index XOR the history zero-extended to IDX_W bits (HIST_W <= IDX_W). It appears in snap_o[2*IDX_W-1:IDX_W].
- R4: The global-only index is the history zero-extended to IDX_W bits and appears in snap_o[3*IDX_W-1:2*IDX_W]. The current history appears in snap_o[3*IDX_W+HIST_W-1:3*IDX_W].
- R5: pred_taken_o is 1 exactly when at least two of the three selected counters have their upper bit set.
- R6: On an update, each of the three counters at the indices taken from upd_snap_i counts up on taken and down on not-taken. Counters saturate at 3 and 0.
- R7: On an update with upd_mispred_i low, the history becomes {history[HIST_W-2:0], upd_taken_i}, and the snapshot's history field is ignored.
- R8: On an update with upd_mispred_i high, the history becomes {snap_history[HIST_W-2:0], upd_taken_i}, where snap_history is the history field of upd_snap_i.
- R9: No tag is checked. Two addresses with equal bits [IDX_W+1:2] read and train the same bimodal counter.
- R10: A cycle without upd_valid_i changes no counter and no history bit, whatever lookup address is applied.
- R11: An update takes effect at the clock edge that ends its cycle. A lookup in the same cycle sees the old state, and a lookup in the next cycle sees the new state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_pc_i | input | PC_W | Fetch address of the branch being predicted |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| snap_o | output | 3*IDX_W+HIST_W | {history, global idx, gshare idx, bimodal idx} used by this lookup |
| upd_valid_i | input | 1 | A resolved conditional branch is presented |
| upd_taken_i | input | 1 | Actual direction of the resolved branch |
| upd_mispred_i | input | 1 | The resolved branch had been mispredicted |
| upd_snap_i | input | 3*IDX_W+HIST_W | Snapshot saved at lookup for the resolved branch |

## Verification
A corrupted history bit shows up at once in the history field of snap_o, and in the gshare and global index fields, on the very next lookup. A wrong counter update or a wrong table choice stays hidden until it tips a majority vote. That can take several updates of the same entry, so the bench drives long training runs per address and checks every lookup against an independent counter model. Aliased addresses, saturated entries and mispredict restores with a history unlike the current one are exercised so that such faults reach pred_taken_o.

// File: rtl/tvbp_pkg.sv
package tvbp_pkg;
  localparam logic [1:0] CTR_INIT = 2'b01;
  localparam int TBL_BIM = 0;
  localparam int TBL_GSH = 1;
  localparam int TBL_GLB = 2;
  localparam int N_TBL   = 3;

  function automatic logic [1:0] sat_step(input logic [1:0] cur, input logic up);
    if (up) return (cur == 2'b11) ? cur : cur + 2'b01;
    else    return (cur == 2'b00) ? cur : cur - 2'b01;
  endfunction

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/ctr_table.sv
module ctr_table
  import tvbp_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  logic [1:0] ctr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= sat_step(ctr_q[wr_idx_i], wr_taken_i);
    end
  end

  assign rd_taken_o = ctr_q[rd_idx_i][1];
endmodule

// File: rtl/glob_hist.sv
module glob_hist #(
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_valid_i,
  input  logic              upd_taken_i,
  input  logic              upd_mispred_i,
  input  logic [HIST_W-1:0] snap_hist_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] base;

  // mispredict: rebuild from the history the branch saw
  assign base = upd_mispred_i ? snap_hist_i : hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hist_q <= '0;
    else if (upd_valid_i) hist_q <= {base[HIST_W-2:0], upd_taken_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/tri_vote_bpred.sv
module tri_vote_bpred
  import tvbp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PC_W-1:0]           lookup_pc_i,
  output logic                      pred_taken_o,
  output logic [3*IDX_W+HIST_W-1:0] snap_o,
  input  logic                      upd_valid_i,
  input  logic                      upd_taken_i,
  input  logic                      upd_mispred_i,
  input  logic [3*IDX_W+HIST_W-1:0] upd_snap_i
);
  localparam int H_LO = 3 * IDX_W;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  hist_ext;
  logic [IDX_W-1:0]  rd_idx [N_TBL];
  logic [IDX_W-1:0]  wr_idx [N_TBL];
  logic [N_TBL-1:0]  vote;
  logic              unused_pc;

  assign unused_pc = ^{lookup_pc_i[PC_W-1:IDX_W+2], lookup_pc_i[1:0]};
  assign hist_ext  = IDX_W'(hist);

  assign rd_idx[TBL_BIM] = lookup_pc_i[IDX_W+1:2];
  assign rd_idx[TBL_GSH] = lookup_pc_i[IDX_W+1:2] ^ hist_ext;
  assign rd_idx[TBL_GLB] = hist_ext;

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    assign wr_idx[t] = upd_snap_i[t*IDX_W +: IDX_W];
    ctr_table #(.IDX_W(IDX_W)) u_tbl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_idx_i   (rd_idx[t]),
      .rd_taken_o (vote[t]),
      .wr_en_i    (upd_valid_i),
      .wr_idx_i   (wr_idx[t]),
      .wr_taken_i (upd_taken_i)
    );
    assign snap_o[t*IDX_W +: IDX_W] = rd_idx[t];
  end

  glob_hist #(.HIST_W(HIST_W)) u_hist (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .upd_valid_i   (upd_valid_i),
    .upd_taken_i   (upd_taken_i),
    .upd_mispred_i (upd_mispred_i),
    .snap_hist_i   (upd_snap_i[H_LO +: HIST_W]),
    .hist_o        (hist)
  );

  assign snap_o[H_LO +: HIST_W] = hist;
  assign pred_taken_o = maj3(vote);
endmodule

// File: rtl/tri_vote_bpred_chk.sv
module tri_vote_bpred_chk #(
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [IDX_W-1:0]          lookup_idx_i,
  input logic [3*IDX_W+HIST_W-1:0] snap_o,
  input logic                      upd_valid_i,
  input logic                      upd_taken_i,
  input logic                      upd_mispred_i,
  input logic [HIST_W-1:0]         upd_hist_i
);
  localparam int H_LO = 3 * IDX_W;
  logic [HIST_W-1:0] hist_w;
  logic [IDX_W-1:0]  bim_w, gsh_w, glb_w;
  assign hist_w = snap_o[H_LO +: HIST_W];
  assign bim_w  = snap_o[0 +: IDX_W];
  assign gsh_w  = snap_o[IDX_W +: IDX_W];
  assign glb_w  = snap_o[2*IDX_W +: IDX_W];

  AST_BIM_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bim_w == lookup_idx_i); // R2
  AST_GSH_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gsh_w == (lookup_idx_i ^ IDX_W'(hist_w))); // R3
  AST_GLB_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_w == IDX_W'(hist_w)); // R4
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> hist_w == $past(hist_w)); // R10
  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_mispred_i |=>
      hist_w == {$past(hist_w[HIST_W-2:0]), $past(upd_taken_i)}); // R7
  AST_HIST_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_mispred_i |=>
      hist_w == {$past(upd_hist_i[HIST_W-2:0]), $past(upd_taken_i)}); // R8
endmodule

bind tri_vote_bpred tri_vote_bpred_chk #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lookup_idx_i  (lookup_pc_i[IDX_W+1:2]),
  .snap_o        (snap_o),
  .upd_valid_i   (upd_valid_i),
  .upd_taken_i   (upd_taken_i),
  .upd_mispred_i (upd_mispred_i),
  .upd_hist_i    (upd_snap_i[3*IDX_W +: HIST_W])
);

// File: tb/tri_vote_bpred_tb.sv
module tri_vote_bpred_tb;
  localparam int PC_W = 32, IDX_W = 8, HIST_W = 8;
  localparam int SNAP_W = 3*IDX_W + HIST_W;
  localparam int DEPTH = 1 << IDX_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [PC_W-1:0] lookup_pc_i = '0;
  logic pred_taken_o;
  logic [SNAP_W-1:0] snap_o;
  logic upd_valid_i = 1'b0, upd_taken_i = 1'b0, upd_mispred_i = 1'b0;
  logic [SNAP_W-1:0] upd_snap_i = '0;

  always #2 clk_i = ~clk_i;

  tri_vote_bpred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_dut (.*);

  typedef struct { logic pred; logic [SNAP_W-1:0] snap; string req; } exp_t;
  exp_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int bim_m[DEPTH], gsh_m[DEPTH], glb_m[DEPTH];
  logic [HIST_W-1:0] hist_m = '0;

  function automatic logic [SNAP_W-1:0] mk_snap(input logic [PC_W-1:0] pc);
    logic [IDX_W-1:0] bi, gi, li;
    bi = pc[IDX_W+1:2];
    li = IDX_W'(hist_m);
    gi = bi ^ li;
    return {hist_m, li, gi, bi};
  endfunction

  function automatic logic m_pred(input logic [PC_W-1:0] pc);
    logic [SNAP_W-1:0] s;
    int n;
    s = mk_snap(pc);
    n = (bim_m[s[IDX_W-1:0]] >= 2 ? 1 : 0) + (gsh_m[s[2*IDX_W-1:IDX_W]] >= 2 ? 1 : 0)
      + (glb_m[s[3*IDX_W-1:2*IDX_W]] >= 2 ? 1 : 0);
    return n >= 2;
  endfunction

  function automatic int sat(input int v, input logic t);
    if (t) return (v < 3) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: one cycle of lookup plus optional update
  task automatic step(input logic [PC_W-1:0] pc, input logic uv, input logic ut,
                      input logic um, input logic [SNAP_W-1:0] us, input string req);
    exp_t e;
    @(posedge clk_i); #1;
    lookup_pc_i = pc; upd_valid_i = uv; upd_taken_i = ut;
    upd_mispred_i = um; upd_snap_i = us;
    e.pred = m_pred(pc); e.snap = mk_snap(pc); e.req = req;
    sb_q.push_back(e);
    if (uv) begin
      bim_m[us[IDX_W-1:0]]         = sat(bim_m[us[IDX_W-1:0]], ut);
      gsh_m[us[2*IDX_W-1:IDX_W]]   = sat(gsh_m[us[2*IDX_W-1:IDX_W]], ut);
      glb_m[us[3*IDX_W-1:2*IDX_W]] = sat(glb_m[us[3*IDX_W-1:2*IDX_W]], ut);
      hist_m = um ? {us[SNAP_W-2:3*IDX_W], ut} : {hist_m[HIST_W-2:0], ut};
    end
  endtask

  task automatic branch(input logic [PC_W-1:0] pc, input logic t, input string req);
    logic [SNAP_W-1:0] s;
    logic p;
    s = mk_snap(pc); p = m_pred(pc);
    step(pc, 0, 0, 0, '0, req);
    step(pc, 1, t, p != t, s, req);
  endtask

  // monitor
  always @(negedge clk_i) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      chk(pred_taken_o === e.pred, e.req, "pred", 64'(pred_taken_o), 64'(e.pred));
      chk(snap_o === e.snap, e.req, "snap", 64'(snap_o), 64'(e.snap));
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin bim_m[i] = 1; gsh_m[i] = 1; glb_m[i] = 1; end
    repeat (2) begin
      @(negedge clk_i);
      chk(pred_taken_o === 1'b0, "R1", "pred in reset", 64'(pred_taken_o), 0);
      chk(snap_o[SNAP_W-1:3*IDX_W] === '0, "R1", "hist in reset",
          64'(snap_o[SNAP_W-1:3*IDX_W]), 0);
    end
    @(posedge clk_i); #1 rst_ni = 1'b1;
    // R1 R2: fresh lookups over several addresses
    for (int i = 0; i < 8; i++) step(32'h40 * i + 32'h1234_0000 + i, 0, 0, 0, '0, "R1");
    // R6: saturate one address then reverse
    for (int i = 0; i < 10; i++) branch(32'h0000_0100, 1, "R6");
    for (int i = 0; i < 3; i++) branch(32'h0000_0100, 0, "R6");
    // R9: alias of 0x100 differs only above bit IDX_W+1
    for (int i = 0; i < 6; i++) branch(32'h0000_0100, 1, "R9");
    step(32'h0000_0100 + (32'h1 << (IDX_W+2)), 0, 0, 0, '0, "R9");
    step(32'hABC0_0100, 0, 0, 0, '0, "R9");
    // R7: correct update with junk snapshot history
    step(32'h0000_0200, 1, 1, 0, {8'h5A, 24'h00_0000}, "R7");
    step(32'h0000_0200, 1, 0, 0, {8'hC3, 24'h12_3456}, "R7");
    step(32'h0000_0200, 0, 0, 0, '0, "R7");
    // R8: mispredict restore from snapshot
    step(32'h0000_0300, 1, 1, 1, {8'hA5, 24'h01_0203}, "R8");
    step(32'h0000_0300, 1, 0, 1, {8'h3C, 24'h04_0506}, "R8");
    step(32'h0000_0300, 0, 0, 0, '0, "R8");
    // R10: lookups alone change nothing
    for (int i = 0; i < 16; i++) step(32'h0000_0100 + 4*i, 0, 0, 0, '0, "R10");
    // R11: back-to-back updates with same-cycle lookups of the same address
    for (int i = 0; i < 12; i++) begin
      logic [SNAP_W-1:0] s;
      s = mk_snap(32'h0000_0400);
      step(32'h0000_0400, 1, 1, m_pred(32'h0000_0400) != 1'b1, s, "R11");
    end
    // R3 R4 R5: mixed patterns (loop TTTN, alternating, biased random)
    for (int i = 0; i < 120; i++) begin
      branch(32'h0000_0800, (i % 4) != 3, "R5");
      branch(32'h0000_0904, i[0], "R3");
      branch(32'h0000_0A08 + 32'(($urandom % 4) * 4), ($urandom % 8) != 0, "R4");
    end
    @(negedge clk_i); @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule